// File: doc/BRIEF.md
# Host Controller Interrupt Register Block

This block holds the interrupt status and interrupt enable registers of a USB host controller behind a 32-bit register interface. Single-cycle event pulses from the rest of the controller latch into status bits. Software acknowledges an event by writing 1 to its status bit. Status bits for unused event positions stay at zero.

A separate enable register selects which latched events may raise the interrupt. Software sets enable bits by writing 1 at the enable offset and clears them by writing 1 at a companion disable offset. Enable bit 31 is a global master gate. The single level interrupt output is registered.

The block also raises the frame-overflow event itself. It compares the most significant bit (bit 15) of the frame counter with the value it had on the previous clock.

Top module: `hc_irq_regs`

## Requirements
- R1: After reset the status and enable registers both read 0x00000000 and `irq` is 0.
- R2: A pulse on an event input sets its status bit at the next clock edge, and the bit reads back at byte offset 0x0C. The bit positions are: scheduling overrun at 0, done-list writeback at 1, start of frame at 2, resume detected at 3, root hub change at 6 and ownership change at 30.
- R3: A status bit stays set until software writes 1 to it at offset 0x0C, which clears it. Writing 0 to a status bit leaves it unchanged.
- R4: When an event pulse and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Status bits 4, 7 to 29 and 31 always read 0 and ignore writes. Enable bits 4 and 7 to 29 also always read 0 and ignore writes.
- R6: Status bit 5 is set whenever `frame_msb` differs from its value on the previous clock, for both a rise and a fall. The comparison value after reset is 0.
- R7: Writing at offset 0x10 sets every enable bit where the write data holds 1 and leaves the others unchanged. The enable register reads back at 0x10.
- R8: Writing at offset 0x14 clears every enable bit where the write data holds 1, including master bit 31. Reading 0x14 returns the enable register.
- R9: `irq` is 1 exactly one clock after enable bit 31 is 1 and at least one implemented status bit and its enable bit are both 1. Otherwise it is 0.
- R10: Reads at any other offset return 0, and writes there change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current offset |
| addr | input | 8 | Byte offset of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| ev_sched_ovr | input | 1 | Scheduling overrun pulse |
| ev_done_wb | input | 1 | Done-list writeback pulse |
| ev_sof | input | 1 | Start-of-frame pulse |
| ev_resume | input | 1 | Downstream resume detected pulse |
| ev_hub_chg | input | 1 | Root hub status change pulse |
| ev_own_chg | input | 1 | Ownership change request pulse |
| frame_msb | input | 1 | Bit 15 of the current frame number |
| irq | output | 1 | Level interrupt request |

## Verification
A hardware set and a software clear can land on the same status bit in one cycle. Enable and disable writes never coincide, because they use separate offsets. The bench drives a start-of-frame pulse together with a write of 1 to status bit 2, and also a frame-bit toggle together with a write of 1 to bit 5. The behavioural model expects the bit to stay set and `irq` to stay asserted, and the comparison on every clock judges the outcome.

// File: rtl/hc_irq_regs.sv
module hc_irq_regs #(
  parameter int             AW      = 8,
  parameter logic [AW-1:0]  STS_OFS = 8'h0C,
  parameter logic [AW-1:0]  ENA_OFS = 8'h10,
  parameter logic [AW-1:0]  DIS_OFS = 8'h14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          ev_sched_ovr,
  input  logic          ev_done_wb,
  input  logic          ev_sof,
  input  logic          ev_resume,
  input  logic          ev_hub_chg,
  input  logic          ev_own_chg,
  input  logic          frame_msb,
  output logic          irq
);
  localparam logic [31:0] EVT_MASK = 32'h4000_006F;
  localparam logic [31:0] ENA_MASK = EVT_MASK | 32'h8000_0000;

  logic [31:0] sts, ena;
  logic        frame_q;

  wire sts_wr = wr_en && (addr == STS_OFS);
  wire ena_wr = wr_en && (addr == ENA_OFS);
  wire dis_wr = wr_en && (addr == DIS_OFS);

  wire [31:0] hw_set = {1'b0, ev_own_chg, 23'd0, ev_hub_chg, frame_msb ^ frame_q,
                        1'b0, ev_resume, ev_sof, ev_done_wb, ev_sched_ovr};
  wire [31:0] sw_clr = sts_wr ? wdata : 32'd0;
  wire [31:0] sw_on  = ena_wr ? wdata : 32'd0;
  wire [31:0] sw_off = dis_wr ? wdata : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts     <= '0;
      ena     <= '0;
      frame_q <= 1'b0;
      irq     <= 1'b0;
    end else begin
      sts     <= ((sts & ~sw_clr) | hw_set) & EVT_MASK;
      ena     <= ((ena | sw_on) & ~sw_off) & ENA_MASK;
      frame_q <= frame_msb;
      irq     <= ena[31] & (|(sts & ena & EVT_MASK));
    end
  end

  always_comb begin
    if (addr == STS_OFS)                          rdata = sts;
    else if (addr == ENA_OFS || addr == DIS_OFS)  rdata = ena;
    else                                          rdata = '0;
  end

  AST_SOF_LATCH:  assert property (@(posedge clk) disable iff (!rst_n)
    ev_sof |=> sts[2]);                                                  // R2
  AST_STS_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
    !sts_wr |=> ((sts & $past(sts)) == $past(sts)));                     // R3
  AST_CLR_TAKES:  assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && wdata[0] && !ev_sched_ovr) |=> !sts[0]);                  // R3
  AST_SET_WINS:   assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && wdata[2] && ev_sof) |=> sts[2]);                          // R4
  AST_ENA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !dis_wr |=> ((ena & $past(ena)) == $past(ena)));                     // R7
  AST_NO_MASTER:  assert property (@(posedge clk) disable iff (!rst_n)
    !ena[31] |=> !irq);                                                  // R9
endmodule

// File: tb/test_hc_irq_regs.sv
module test_hc_irq_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  ev = '0;
  logic        frame_msb = 1'b0;
  logic        irq;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  logic [31:0] m_sts = '0, m_ena = '0;
  logic        m_irq = 1'b0, m_fq = 1'b0;
  int          evpos[6] = '{0, 1, 2, 3, 6, 30};

  always #5 clk = ~clk;

  hc_irq_regs i_hc_irq_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ev_sched_ovr(ev[0]), .ev_done_wb(ev[1]), .ev_sof(ev[2]),
    .ev_resume(ev[3]), .ev_hub_chg(ev[4]), .ev_own_chg(ev[5]),
    .frame_msb(frame_msb), .irq(irq));

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a == 8'h0C) return m_sts;
    if (a == 8'h10 || a == 8'h14) return m_ena;
    return 32'd0;
  endfunction

  function automatic bool_impl(input int b);
    return (b <= 3) || b == 5 || b == 6 || b == 30;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic w, input logic [7:0] a,
                      input logic [31:0] d, input logic [5:0] e, input logic fm);
    logic [31:0] ns, ne;
    logic        ni;
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; ev = e; frame_msb = fm;
    @(posedge clk);
    ns = m_sts; ne = m_ena; ni = 1'b0;
    for (int b = 0; b < 32; b++) begin
      if (w && a == 8'h0C && d[b]) ns[b] = 1'b0;
      if (w && a == 8'h10 && d[b] && (bool_impl(b) || b == 31)) ne[b] = 1'b1;
      if (w && a == 8'h14 && d[b]) ne[b] = 1'b0;
      if (bool_impl(b) && m_sts[b] && m_ena[b] && m_ena[31]) ni = 1'b1;
    end
    for (int k = 0; k < 6; k++) if (e[k]) ns[evpos[k]] = 1'b1;
    if (fm != m_fq) ns[5] = 1'b1;
    m_sts = ns; m_ena = ne; m_irq = ni; m_fq = fm;
    #1;
    check({tag, " irq"}, {31'd0, irq}, {31'd0, m_irq});
    check({tag, " rdata"}, rdata, m_read(addr));
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic fm);
    step(tag, 1'b0, a, 32'd0, 6'd0, fm);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    addr = 8'h0C; #1; check("R1 sts", rdata, 32'd0);
    addr = 8'h10; #1; check("R1 ena", rdata, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    step("R7 set all", 1, 8'h10, 32'hFFFF_FFFF, 0, 0);
    rd("R5 ena mask", 8'h10, 0);
    step("R7 write zero", 1, 8'h10, 32'h0, 0, 0);
    rd("R7 hold", 8'h10, 0);
    step("R8 drop master", 1, 8'h14, 32'h8000_0000, 0, 0);
    rd("R8 read 14", 8'h14, 0);
    for (int k = 0; k < 6; k++) begin
      step("R2 event", 0, 8'h0C, 0, 6'(1 << k), 0);
      rd("R9 no master", 8'h0C, 0);
    end
    step("R9 master on", 1, 8'h10, 32'h8000_0000, 0, 0);
    rd("R9 irq rises", 8'h0C, 0);
    step("R3 write zero", 1, 8'h0C, 32'h0, 0, 0);
    step("R3 clear low", 1, 8'h0C, 32'h0000_000F, 0, 0);
    rd("R3 after", 8'h0C, 0);
    step("R4 sof vs clear", 1, 8'h0C, 32'h0000_0004, 6'b000100, 0);
    rd("R4 after", 8'h0C, 0);
    step("R3 clear all", 1, 8'h0C, 32'hFFFF_FFFF, 0, 0);
    rd("R9 irq falls", 8'h0C, 0);
    rd("R6 rise", 8'h0C, 1);
    rd("R6 steady", 8'h0C, 1);
    step("R4 frame vs clear", 1, 8'h0C, 32'h0000_0020, 0, 0);
    rd("R6 fall", 8'h0C, 0);
    step("R6 clear", 1, 8'h0C, 32'h0000_0020, 0, 0);
    rd("R9 idle", 8'h0C, 0);
    step("R5 sts reserved", 1, 8'h0C, 32'hBFFF_FF90, 0, 0);
    step("R8 clear ena", 1, 8'h14, 32'hFFFF_FFFF, 0, 0);
    rd("R8 ena zero", 8'h10, 0);
    step("R10 stray write", 1, 8'h18, 32'hFFFF_FFFF, 0, 0);
    rd("R10 ena kept", 8'h10, 0);
    step("R9 partial", 1, 8'h10, 32'h8000_0001, 6'b000010, 0);
    rd("R9 masked", 8'h0C, 0);
    step("R9 own", 1, 8'h10, 32'h4000_0000, 6'b100000, 0);
    rd("R9 own irq", 8'h0C, 0);
    rd("R9 hold", 8'h0C, 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule